// File: doc/BRIEF.md
# Dual-Channel Serial Wiper Register Controller

This block is the digital side of a two-channel, 256-position digital potentiometer. A serial slave port (chip select, serial clock, serial data in) loads 16-bit frames made of a command byte and a data byte. When chip select returns high, the last complete frame is decoded. It can write a new 8-bit tap code to any set of channels, put channels into software shutdown, or do nothing. For each channel the block drives the wiper code, a flag that opens the A terminal, and a flag that ties the wiper to B. The resistor ladder itself is not part of the block.

A serial data output repeats the stream delayed by exactly 16 clocks, so several devices can share one chip select in a chain. The output changes on the falling serial clock edge, and its output enable is high only while chip select is low. Both clock polarities work: the clock may idle low or high, and data is always taken on the rising edge. An active-low reset pin puts every wiper back to mid-scale. An active-low shutdown pin forces shutdown on all channels. The wiper codes stay writable during any shutdown.

The serial pins are sampled by the system clock `clk`. Edges are found by comparing each pin with its value one cycle earlier, so the pins are expected to be synchronous to `clk` already.

Top module: `potWiperCtrl`

## Requirements
- R1: While `rstN` is low, and after it is released, every wiper code is 0x80, both shutdown flags are 0 on every channel (with `shdnN` high), and `sdo` is 0.
- R2: Bits are taken MSB first on each rising `sck` while `csN` is low. In a frame, bit 15..8 is the command byte and bit 7..0 is the data. Frame bits 13:12 = 01 means write. A write loads the data into channel 0 if frame bit 8 is set and into channel 1 if frame bit 9 is set.
- R3: A frame takes effect only in the cycle after `csN` rises, and only if the number of rising `sck` edges since `csN` fell is a nonzero multiple of 16. With any other count, nothing changes.
- R4: Frame bits 13:12 = 10 sets software shutdown on the selected channels, which drives both of that channel's flags to 1. A write to a channel clears its software shutdown.
- R5: While `shdnN` is low, both flags of every channel are 1 and the codes are kept. Writes still load the codes, and the new codes remain when `shdnN` goes high.
- R6: Command values 00 and 11 in frame bits 13:12 change neither codes nor flags.
- R7: On each falling `sck` while `csN` is low, `sdo` takes the bit that entered 16 rising edges earlier (zero if none since reset). In a 32-bit burst, the first 16 bits come out during edges 17..32, and the last 16 bits are the frame that executes locally.
- R8: `sdoEn` is 1 exactly while `csN` is low.
- R9: Frames work the same way whether `sck` idles low or high.
- R10: `sck` edges while `csN` is high shift nothing and execute nothing.
- R11: Pulling `rstN` low in the middle of operation brings the codes back to 0x80 and clears software shutdown.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial pins |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| shdnN | input | 1 | Active-low hardware shutdown |
| sdo | output | 1 | Serial data out, delayed by 16 bits |
| sdoEn | output | 1 | Output enable for `sdo` |
| wiperCode | output | 16 | Tap codes, channel c at bits c*8+7..c*8 |
| termAOpen | output | 2 | Per channel: A terminal disconnected |
| wiperToB | output | 2 | Per channel: wiper tied to B |

## Verification
The assertions assume that `sck` and `csN` are synchronous to `clk` and that each level lasts at least one cycle, so every edge is seen exactly once. They also assume that `csN` and `sck` never change in the same cycle. The stimulus holds every serial level for two clock cycles and changes chip select only while the clock is idle. It covers both idle polarities, short and long bursts, and clock activity while deselected, so the counting and abort rules are exercised without breaking these assumptions.

// File: rtl/potCtrlPkg.sv
package potCtrlPkg;

  typedef enum logic [1:0] {
    CMD_NOP_LO = 2'b00,
    CMD_WRITE  = 2'b01,
    CMD_SHDN   = 2'b10,
    CMD_NOP_HI = 2'b11
  } potCmd_t;

  typedef struct packed {
    logic shift;    // rising sck inside a select window
    logic fall;     // falling sck inside a select window
    logic csStart;  // chip select just went low
    logic exec;     // chip select just went high after whole frames
  } potStrobe_t;

endpackage

// File: rtl/potSpiCtrl.sv
module potSpiCtrl
  import potCtrlPkg::*;
#(
  parameter int FRAME_W = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sck,
  output potStrobe_t strb
);
  localparam int CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic             sckPrev;
  logic             csPrev;
  logic [CNT_W-1:0] bitCnt;
  logic             fullSeen;

  always_comb begin
    strb.shift   = !sckPrev && sck && !csN;
    strb.fall    = sckPrev && !sck && !csN;
    strb.csStart = csPrev && !csN;
    strb.exec    = !csPrev && csN && fullSeen && (bitCnt == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPrev  <= 1'b0;
      csPrev   <= 1'b1;
      bitCnt   <= '0;
      fullSeen <= 1'b0;
    end else begin
      sckPrev <= sck;
      csPrev  <= csN;
      if (strb.csStart) begin
        bitCnt   <= '0;
        fullSeen <= 1'b0;
      end else if (strb.shift) begin
        if (bitCnt == LAST) begin
          bitCnt   <= '0;
          fullSeen <= 1'b1;
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end

  // R3: a new select window starts counting from zero
  a_r3_count_cleared: assert property (@(posedge clk) disable iff (!rstN)
    strb.csStart |=> (bitCnt == '0 && !fullSeen));

endmodule

// File: rtl/potDatapath.sv
module potDatapath
  import potCtrlPkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CODE_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sdi,
  input  logic                     shdnN,
  input  potStrobe_t               strb,
  output logic                     sdo,
  output logic [NUM_CH*CODE_W-1:0] wiperCode,
  output logic [NUM_CH-1:0]        termAOpen,
  output logic [NUM_CH-1:0]        wiperToB
);
  localparam int FRAME_W = 2 * CODE_W;
  localparam logic [CODE_W-1:0] MID_CODE = {1'b1, {(CODE_W-1){1'b0}}};

  logic [FRAME_W-1:0] shiftQ;
  logic               sdoQ;
  logic [NUM_CH-1:0]  swShdn;
  potCmd_t            cmd;
  logic [NUM_CH-1:0]  sel;
  logic [CODE_W-1:0]  data;
  logic               wrEn;
  logic               sdEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '0;
      sdoQ   <= 1'b0;
    end else begin
      if (strb.shift) shiftQ <= {shiftQ[FRAME_W-2:0], sdi};
      if (strb.fall)  sdoQ   <= shiftQ[FRAME_W-1];
    end
  end

  always_comb begin
    cmd  = potCmd_t'(shiftQ[CODE_W+5 -: 2]);
    sel  = shiftQ[CODE_W +: NUM_CH];
    data = shiftQ[CODE_W-1:0];
    wrEn = strb.exec && (cmd == CMD_WRITE);
    sdEn = strb.exec && (cmd == CMD_SHDN);
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    logic [CODE_W-1:0] wiperQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        wiperQ    <= MID_CODE;
        swShdn[g] <= 1'b0;
      end else if (wrEn && sel[g]) begin
        wiperQ    <= data;
        swShdn[g] <= 1'b0;
      end else if (sdEn && sel[g]) begin
        swShdn[g] <= 1'b1;
      end
    end
    assign wiperCode[g*CODE_W +: CODE_W] = wiperQ;
  end

  assign sdo       = sdoQ;
  assign termAOpen = swShdn | {NUM_CH{~shdnN}};
  assign wiperToB  = swShdn | {NUM_CH{~shdnN}};

  // R3: codes move only after an accepted frame
  a_r3_code_needs_exec: assert property (@(posedge clk) disable iff (!rstN)
    !strb.exec |=> $stable(wiperCode));

  // R6: no-operation commands leave codes and shutdown state alone
  a_r6_nop_is_inert: assert property (@(posedge clk) disable iff (!rstN)
    (strb.exec && (cmd == CMD_NOP_LO || cmd == CMD_NOP_HI))
      |=> ($stable(wiperCode) && $stable(swShdn)));

  // R4: shutdown command leaves every selected channel shut down
  a_r4_shdn_applied: assert property (@(posedge clk) disable iff (!rstN)
    sdEn |=> ((swShdn & $past(sel)) == $past(sel)));

  // R7: serial output moves only on a falling clock inside a window
  a_r7_sdo_on_fall_only: assert property (@(posedge clk) disable iff (!rstN)
    !strb.fall |=> $stable(sdo));

endmodule

// File: rtl/potWiperCtrl.sv
module potWiperCtrl
  import potCtrlPkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CODE_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     csN,
  input  logic                     sck,
  input  logic                     sdi,
  input  logic                     shdnN,
  output logic                     sdo,
  output logic                     sdoEn,
  output logic [NUM_CH*CODE_W-1:0] wiperCode,
  output logic [NUM_CH-1:0]        termAOpen,
  output logic [NUM_CH-1:0]        wiperToB
);
  localparam int FRAME_W = 2 * CODE_W;

  potStrobe_t strb;

  potSpiCtrl #(.FRAME_W(FRAME_W)) u_ctrl (
    .clk (clk),
    .rstN(rstN),
    .csN (csN),
    .sck (sck),
    .strb(strb)
  );

  potDatapath #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .sdi      (sdi),
    .shdnN    (shdnN),
    .strb     (strb),
    .sdo      (sdo),
    .wiperCode(wiperCode),
    .termAOpen(termAOpen),
    .wiperToB (wiperToB)
  );

  assign sdoEn = ~csN;

endmodule

// File: tb/potWiperCtrl_bench.sv
module potWiperCtrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1;
  logic        sck = 1'b0;
  logic        sdi = 1'b0;
  logic        shdnN = 1'b1;
  logic        sdo;
  logic        sdoEn;
  logic [15:0] wiperCode;
  logic [1:0]  termAOpen;
  logic [1:0]  wiperToB;

  int checks = 0;
  int fails  = 0;

  potWiperCtrl u_potWiperCtrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .sdi(sdi), .shdnN(shdnN),
    .sdo(sdo), .sdoEn(sdoEn), .wiperCode(wiperCode),
    .termAOpen(termAOpen), .wiperToB(wiperToB)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mWiper[2];
  bit mSw[2];
  bit hist[$];
  int mCount;
  bit mSdo, mSckP, mCsP;

  always @(posedge clk) begin
    if (!rstN) begin
      mWiper[0] = 'h80; mWiper[1] = 'h80;
      mSw[0] = 0; mSw[1] = 0;
      hist.delete();
      for (int i = 0; i < 16; i++) hist.push_back(1'b0);
      mCount = 0; mSdo = 0; mSckP = 0; mCsP = 1;
    end else begin
      if (mCsP && !csN) mCount = 0;
      if (!mSckP && sck && !csN) begin
        hist.push_back(sdi);
        void'(hist.pop_front());
        mCount++;
      end
      if (mSckP && !sck && !csN) mSdo = hist[0];
      if (!mCsP && csN && mCount > 0 && (mCount % 16) == 0) begin
        int op, d;
        bit s[2];
        op = hist[2] * 2 + hist[3];
        s[0] = hist[7]; s[1] = hist[6];
        d = 0;
        for (int j = 0; j < 8; j++) d = d * 2 + hist[8 + j];
        for (int c = 0; c < 2; c++) begin
          if (s[c] && op == 1) begin mWiper[c] = d; mSw[c] = 0; end
          else if (s[c] && op == 2) mSw[c] = 1;
        end
      end
      mSckP = sck; mCsP = csN;
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      logic [1:0] f;
      f = {mSw[1] | !shdnN, mSw[0] | !shdnN};
      chk("R2 cycle wiperCode", wiperCode, {mWiper[1][7:0], mWiper[0][7:0]});
      chk("R4 cycle termAOpen", termAOpen, f);
      chk("R5 cycle wiperToB", wiperToB, f);
      chk("R7 cycle sdo", sdo, mSdo);
      chk("R8 cycle sdoEn", sdoEn, !csN);
    end
  end

  // ---------------- stimulus ----------------
  logic cap[64];

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      #(CLK_PERIOD/4);
    end
  endtask

  task automatic sendBits(input logic [63:0] v, input int n, input bit idleHigh);
    sck = idleHigh; step(2);
    csN = 1'b0; step(2);
    for (int i = 0; i < n; i++) begin
      sck = 1'b0; sdi = v[n-1-i]; step(2);
      cap[i] = sdo;
      sck = 1'b1; step(2);
    end
    sck = idleHigh; step(2);
    csN = 1'b1; step(3);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired, all requirements");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    step(3);
    chk("R1 reset wiperCode", wiperCode, 16'h8080);
    chk("R1 reset flags", {termAOpen, wiperToB}, 4'h0);
    chk("R1 reset sdo", sdo, 1'b0);
    chk("R8 sdoEn idle", sdoEn, 1'b0);
    rstN = 1'b1; step(2);
    chk("R1 after release wiperCode", wiperCode, 16'h8080);

    sendBits(64'h113C, 16, 0);
    chk("R2 write ch0", wiperCode, 16'h803C);

    sendBits(64'h13A5, 16, 1);
    chk("R9 idle-high write both", wiperCode, 16'hA5A5);

    sendBits(64'h1100 >> 1, 15, 0);
    chk("R3 15 clocks aborted", wiperCode, 16'hA5A5);
    sendBits({16'h1100, 1'b0}, 17, 0);
    chk("R3 17 clocks aborted", wiperCode, 16'hA5A5);

    sendBits(64'h0355, 16, 0);
    sendBits(64'h3355, 16, 1);
    chk("R6 nop codes", wiperCode, 16'hA5A5);
    chk("R6 nop flags", {termAOpen, wiperToB}, 4'h0);

    sendBits(64'h2200, 16, 0);
    chk("R4 shutdown ch1 A open", termAOpen, 2'b10);
    chk("R4 shutdown ch1 to B", wiperToB, 2'b10);
    sendBits(64'h1240, 16, 0);
    chk("R4 write exits shutdown", termAOpen, 2'b00);
    chk("R4 write code", wiperCode, 16'h40A5);

    shdnN = 1'b0; step(1);
    chk("R5 hw shutdown flags", {termAOpen, wiperToB}, 4'hF);
    chk("R5 hw shutdown codes kept", wiperCode, 16'h40A5);
    sendBits(64'h1111, 16, 0);
    chk("R5 write during shutdown", wiperCode, 16'h4011);
    chk("R5 still shut down", termAOpen, 2'b11);
    shdnN = 1'b1; step(1);
    chk("R5 release flags", {termAOpen, wiperToB}, 4'h0);
    chk("R5 release code", wiperCode, 16'h4011);

    sdi = 1'b1;
    for (int k = 0; k < 5; k++) begin
      sck = 1'b1; step(2); sck = 1'b0; step(2);
    end
    chk("R10 clocks while deselected", wiperCode, 16'h4011);
    sendBits(64'h2100 >> 4, 12, 0);
    chk("R10 no stray count", termAOpen, 2'b00);

    sendBits({32'h0, 16'h1155, 16'h1299}, 32, 0);
    chk("R7 chain local frame", wiperCode, 16'h9911);
    for (int k = 0; k < 16; k++)
      chk($sformatf("R7 chain sdo bit %0d", k), cap[16 + k], 1'(16'h1155 >> (15 - k)));

    sendBits(64'h2300, 16, 0);
    chk("R11 pre-reset shutdown", termAOpen, 2'b11);
    rstN = 1'b0; step(1);
    chk("R11 reset codes", wiperCode, 16'h8080);
    chk("R11 reset flags", {termAOpen, wiperToB}, 4'h0);
    rstN = 1'b1; step(2);
    sendBits(64'h11C3, 16, 1);
    chk("R11 operation after reset", wiperCode, 16'h80C3);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule